// File: doc/BRIEF.md
# CMI Line Codec with Test Loopback

This block pairs a Coded Mark Inversion encoder with a CMI decoder and adds two test loopback paths. Each side runs from its own clock at twice the bit rate. The encoder turns every binary bit into two line symbols. A zero becomes a low half followed by a high half. A one becomes two equal halves, and successive ones alternate between a high pair and a low pair. The decoder reverses the mapping and produces one bit per symbol pair. Each side also drives a bit-rate clock, which is its input clock divided by two.

Two control inputs select the mode. With both low, the two sides work independently. Binary loopback routes the sampled binary input back to the binary output, and the line output then carries an alarm stream of all ones. CMI loopback decodes the incoming line, encodes it again in the decoder clock domain, and sends it to the line output. Setting both controls together is an invalid combination. In that case the block drives every data and clock output low and raises an error flag. Reset overrides every mode.

Top module: `cmi_loop_codec`

## Requirements
- R1: In normal mode (both loopback controls low), a binary 0 appears on `cmi_out` as a low half then a high half. A binary 1 appears as two equal halves. The first 1 after reset is a high pair, and each later 1 takes the opposite level of the previous 1.
- R2: The encoder samples `bin_in` at the clock edges numbered 0, 2, 4 and so on, counted from the first edge after reset. A bit sampled at edge k shows its first half on `cmi_out` after edge k+3 and its second half after edge k+4. Before the first sampled bit arrives, the encoder sends an encoded 0.
- R3: The decoder takes `cmi_in` at edges j and j+1, where j is even. Equal halves decode to 1 and unequal halves decode to 0. The decoded bit appears on `bin_out` after edge j+4 and holds for two edges. Before that, `bin_out` is 0.
- R4: In every legal mode, `cmi_clk_out` and `bin_clk_out` are low during reset, high after edge 0, and toggle on every edge after that.
- R5: In binary loopback, a bit sampled at edge k appears on `bin_out` after edge k+3 and holds for two edges. `bin_clk_out` follows the encoder-side divided clock.
- R6: In binary loopback, `cmi_out` carries the encoding of a constant 1 from edge 1 onward: a high pair, then a low pair, alternating. Both halves of each pair are equal.
- R7: In CMI loopback, the decoded bit from the symbol pair starting at edge j is encoded again. Its first half appears on `cmi_out` after edge j+5. Before that, two encoded 0 bits are sent. `bin_out` keeps showing the decoded data as in R3.
- R8: With both loopback controls high, `cmi_out`, `cmi_clk_out`, `bin_out` and `bin_clk_out` are low and `mode_err` is high. In every legal mode, `mode_err` is low.
- R9: While `rst_n` is low, every output is low. After release, all pipelines restart from edge 0 as if freshly powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Encoder clock, twice the bit rate |
| dclk | input | 1 | Decoder clock, twice the bit rate |
| rst_n | input | 1 | Active-low reset, synchronous to both clocks |
| bin_in | input | 1 | Binary data into the encoder |
| cmi_in | input | 1 | CMI line symbols into the decoder |
| loop_bin | input | 1 | Binary loopback select |
| loop_cmi | input | 1 | CMI loopback select |
| cmi_out | output | 1 | CMI line output |
| cmi_clk_out | output | 1 | Bit-rate clock for the line output |
| bin_out | output | 1 | Binary data output |
| bin_clk_out | output | 1 | Bit-rate clock for the binary output |
| mode_err | output | 1 | High when both loopback controls are set |

## Verification
The assertions assume three things about the inputs. The loopback controls change only while reset is held. `rst_n` is synchronous to both clocks. Symbol framing starts at the first edge after reset, so the first symbol taken there is the first half of a bit. The bench meets these assumptions by tying both clocks to one source, by changing the mode only inside a reset phase, and by holding each binary bit for two clocks. It builds `cmi_in` only from well-formed symbol pairs encoded from random or constant bit streams.

// File: rtl/cmi_pkg.sv
// Shared types and the symbol-pair mapping used by both encoder instances.
// Assumes one bit per two clock cycles; pair bit 1 is sent first.
package cmi_pkg;

    // Loopback selection as {loop_bin, loop_cmi}.
    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_LCMI = 2'b01,
        MODE_LBIN = 2'b10,
        MODE_BAD  = 2'b11
    } lb_mode_e;

    // Map one bit to its two line halves; disp selects the level of the next mark.
    function automatic logic [1:0] cmi_pair(input logic bit_v, input logic disp);
        if (!bit_v) begin
            return 2'b01;
        end
        return disp ? 2'b00 : 2'b11;
    endfunction

endpackage

// File: rtl/cmi_enc.sv
// Symbol-pair encoder. Loads a bit on edges where ph is low and emits its
// first half on the next edge and its second half on the one after.
// Assumes ph toggles every cycle and starts low after reset.
module cmi_enc
    import cmi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ph,
    input  logic bit_in,
    output logic line_out
);

    logic [1:0] pair_q;
    logic       disp_q;

    // Encode a new bit once per bit period and track mark alternation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= 2'b00;
            disp_q <= 1'b0;
        end else if (!ph) begin
            pair_q <= cmi_pair(bit_in, disp_q);
            disp_q <= disp_q ^ bit_in;
        end
    end

    // Serialise the held pair: first half on odd edges, second half on even edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_out <= 1'b0;
        end else begin
            line_out <= ph ? pair_q[1] : pair_q[0];
        end
    end

endmodule

// File: rtl/cmi_coder_path.sv
// Encoder-side pipeline. Samples the binary input once per bit, feeds the
// encoder (or a constant 1 while alarm is set) and keeps a delayed copy of
// the sampled bit for binary loopback. Assumes rst_n is synchronous to clk.
module cmi_coder_path (
    input  logic clk,
    input  logic rst_n,
    input  logic bin_in,
    input  logic alarm,
    output logic ph_o,
    output logic line_o,
    output logic lb_bit_o
);

    logic ph_q;
    logic bit_q;
    logic bit_prev_q;
    logic lb_q;

    // Divide-by-two phase that frames bit periods.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end

    // Sample the binary input and keep one older copy at the start of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q      <= 1'b0;
            bit_prev_q <= 1'b0;
        end else if (!ph_q) begin
            bit_q      <= bin_in;
            bit_prev_q <= bit_q;
        end
    end

    // Present the loopback bit three edges after its sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    lb_q <= 1'b0;
        else if (ph_q) lb_q <= bit_prev_q;
    end

    cmi_enc u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph       (ph_q),
        .bit_in   (alarm | bit_q),
        .line_out (line_o)
    );

    assign ph_o     = ph_q;
    assign lb_bit_o = lb_q;

endmodule

// File: rtl/cmi_decoder_path.sv
// Decoder-side pipeline. Takes one symbol pair per bit with framing fixed
// from reset, decodes it, delays the result and also re-encodes it in this
// clock domain for CMI loopback. Assumes rst_n is synchronous to clk.
module cmi_decoder_path (
    input  logic clk,
    input  logic rst_n,
    input  logic cmi_in,
    output logic ph_o,
    output logic bin_o,
    output logic line_o
);

    logic ph_q;
    logic s0_q;
    logic dbit_q;
    logic dbit2_q;
    logic bin_q;

    // Divide-by-two phase; low marks the first half of a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end

    // Capture the first half, then decode the pair on the second half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_q   <= 1'b0;
            dbit_q <= 1'b0;
        end else if (!ph_q) begin
            s0_q   <= cmi_in;
        end else begin
            dbit_q <= (s0_q == cmi_in);
        end
    end

    // Two bit-period stages of delay before the binary output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbit2_q <= 1'b0;
            bin_q   <= 1'b0;
        end else if (!ph_q) begin
            dbit2_q <= dbit_q;
            bin_q   <= dbit2_q;
        end
    end

    cmi_enc u_reenc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph       (ph_q),
        .bit_in   (dbit2_q),
        .line_out (line_o)
    );

    assign ph_o  = ph_q;
    assign bin_o = bin_q;

endmodule

// File: rtl/cmi_loop_codec.sv
// Top level: an encoder path and a decoder path, plus output steering for
// normal, binary-loopback and CMI-loopback modes. Reset and the invalid
// mode force every output low. Assumes the loopback controls are static
// outside reset and that rst_n is synchronous to both clocks.
module cmi_loop_codec
    import cmi_pkg::*;
(
    input  logic cclk,
    input  logic dclk,
    input  logic rst_n,
    input  logic bin_in,
    input  logic cmi_in,
    input  logic loop_bin,
    input  logic loop_cmi,
    output logic cmi_out,
    output logic cmi_clk_out,
    output logic bin_out,
    output logic bin_clk_out,
    output logic mode_err
);

    lb_mode_e mode;
    logic     c_ph, c_line, c_lb;
    logic     d_ph, d_bin, d_line;

    assign mode = lb_mode_e'({loop_bin, loop_cmi});

    cmi_coder_path u_coder (
        .clk      (cclk),
        .rst_n    (rst_n),
        .bin_in   (bin_in),
        .alarm    (mode == MODE_LBIN),
        .ph_o     (c_ph),
        .line_o   (c_line),
        .lb_bit_o (c_lb)
    );

    cmi_decoder_path u_decoder (
        .clk    (dclk),
        .rst_n  (rst_n),
        .cmi_in (cmi_in),
        .ph_o   (d_ph),
        .bin_o  (d_bin),
        .line_o (d_line)
    );

    // Steer data and clocks to the outputs according to the selected mode.
    always_comb begin
        cmi_out     = 1'b0;
        cmi_clk_out = 1'b0;
        bin_out     = 1'b0;
        bin_clk_out = 1'b0;
        mode_err    = 1'b0;
        if (rst_n) begin
            case (mode)
                MODE_RUN: begin
                    cmi_out     = c_line;
                    cmi_clk_out = c_ph;
                    bin_out     = d_bin;
                    bin_clk_out = d_ph;
                end
                MODE_LBIN: begin
                    cmi_out     = c_line;
                    cmi_clk_out = c_ph;
                    bin_out     = c_lb;
                    bin_clk_out = c_ph;
                end
                MODE_LCMI: begin
                    cmi_out     = d_line;
                    cmi_clk_out = d_ph;
                    bin_out     = d_bin;
                    bin_clk_out = d_ph;
                end
                default: begin
                    mode_err    = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/cmi_loop_codec_chk.sv
// Property checker for cmi_loop_codec, attached through bind. Assumes the
// loopback controls change only in reset and both clocks share reset timing.
module cmi_loop_codec_chk (
    input logic cclk,
    input logic dclk,
    input logic rst_n,
    input logic loop_bin,
    input logic loop_cmi,
    input logic cmi_out,
    input logic cmi_clk_out,
    input logic bin_out,
    input logic bin_clk_out,
    input logic mode_err
);

    AST_RESET_QUIET: assert property (@(posedge cclk)
        !rst_n |-> (!cmi_out && !cmi_clk_out && !bin_out && !bin_clk_out && !mode_err)); // R9

    AST_BAD_MODE_QUIET: assert property (@(posedge cclk) disable iff (!rst_n)
        (loop_bin && loop_cmi) |-> (mode_err && !cmi_out && !cmi_clk_out && !bin_out && !bin_clk_out)); // R8

    AST_LINE_CLK_TOGGLE: assert property (@(posedge cclk) disable iff (!rst_n)
        (!loop_bin && !loop_cmi && $past(rst_n) && $stable({loop_bin, loop_cmi}))
        |-> (cmi_clk_out != $past(cmi_clk_out))); // R4

    AST_ALARM_EQUAL_HALVES: assert property (@(posedge cclk) disable iff (!rst_n)
        (loop_bin && !loop_cmi && $past(rst_n) && $past(loop_bin) && !$past(loop_cmi) && cmi_clk_out)
        |-> (cmi_out == $past(cmi_out))); // R6

    AST_LOOP_BIN_HOLD: assert property (@(posedge cclk) disable iff (!rst_n)
        (loop_bin && !loop_cmi && $past(rst_n) && $past(loop_bin) && !$past(loop_cmi) && bin_clk_out)
        |-> $stable(bin_out)); // R5

    AST_DECODE_HOLD: assert property (@(posedge dclk) disable iff (!rst_n)
        (!loop_bin && !$past(loop_bin) && $past(rst_n) && !bin_clk_out)
        |-> $stable(bin_out)); // R3

endmodule

bind cmi_loop_codec cmi_loop_codec_chk u_chk (
    .cclk        (cclk),
    .dclk        (dclk),
    .rst_n       (rst_n),
    .loop_bin    (loop_bin),
    .loop_cmi    (loop_cmi),
    .cmi_out     (cmi_out),
    .cmi_clk_out (cmi_clk_out),
    .bin_out     (bin_out),
    .bin_clk_out (bin_clk_out),
    .mode_err    (mode_err)
);

// File: tb/cmi_loop_codec_tb.sv
// Bench for cmi_loop_codec: random and constant bit streams in every mode,
// with expected outputs computed from the requirements.
module cmi_loop_codec_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, bin_in, cmi_in, loop_bin, loop_cmi;
    logic cmi_out, cmi_clk_out, bin_out, bin_clk_out, mode_err;

    cmi_loop_codec u_dut (
        .cclk        (clk),
        .dclk        (clk),
        .rst_n       (rst_n),
        .bin_in      (bin_in),
        .cmi_in      (cmi_in),
        .loop_bin    (loop_bin),
        .loop_cmi    (loop_cmi),
        .cmi_out     (cmi_out),
        .cmi_clk_out (cmi_clk_out),
        .bin_out     (bin_out),
        .bin_clk_out (bin_clk_out),
        .mode_err    (mode_err)
    );

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    logic bb  [0:79];
    logic db  [0:79];
    logic sym [0:159];

    task automatic chk(input string req, input logic act, input logic exp, input int m);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s edge %0d: actual %b expected %b", req, m, act, exp);
        end
    endtask

    // Bit fed to an encoder at its j-th load: 0 coder, 1 alarm, 2 CMI loopback.
    function automatic logic cstream(input int sel, input int j);
        if (sel == 0) return (j == 0) ? 1'b0 : bb[j-1];
        if (sel == 1) return 1'b1;
        return (j < 2) ? 1'b0 : db[j-2];
    endfunction

    // Expected line level after edge m (R1, R2, R6, R7).
    function automatic logic cmi_exp(input int sel, input int m);
        int   e, j, h;
        logic par, b;
        if (m < 1) return 1'b0;
        e = m - 1; j = e / 2; h = e % 2;
        par = 1'b0;
        for (int k = 0; k < j; k++) par ^= cstream(sel, k);
        b = cstream(sel, j);
        if (!b) return (h == 1);
        return !par;
    endfunction

    task automatic check_edge(input logic lb, input logic lc, input int pat, input int m);
        logic ck;
        ck = ((m + 1) % 2) == 1;
        if (lb && lc) begin
            chk("R8", mode_err, 1'b1, m);
            chk("R8", cmi_out, 1'b0, m);
            chk("R8", cmi_clk_out, 1'b0, m);
            chk("R8", bin_out, 1'b0, m);
            chk("R8", bin_clk_out, 1'b0, m);
        end else begin
            chk("R8", mode_err, 1'b0, m);
            chk("R4", cmi_clk_out, ck, m);
            chk("R4", bin_clk_out, ck, m);
            if (lb) begin
                chk("R5", bin_out, (m < 3) ? 1'b0 : bb[(m-3)/2], m);
                chk("R6", cmi_out, cmi_exp(1, m), m);
            end else begin
                chk("R3", bin_out, (m < 4) ? 1'b0 : db[(m-4)/2], m);
                if (lc) chk("R7", cmi_out, cmi_exp(2, m), m);
                else    chk((pat == 0) ? "R2" : "R1", cmi_out, cmi_exp(0, m), m);
            end
        end
    endtask

    // pat: 0 random, 1 all zero, 2 all one.
    task automatic run(input logic lb, input logic lc, input int pat, input int nbits);
        logic disp;
        @(negedge clk);
        rst_n = 1'b0; loop_bin = lb; loop_cmi = lc; bin_in = 1'b0; cmi_in = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            bb[i] = (pat == 0) ? 1'($urandom()) : (pat == 2);
            db[i] = (pat == 0) ? 1'($urandom()) : (pat == 2);
        end
        disp = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            if (db[i]) begin
                sym[2*i] = !disp; sym[2*i+1] = !disp; disp = !disp;
            end else begin
                sym[2*i] = 1'b0; sym[2*i+1] = 1'b1;
            end
        end
        repeat (3) @(negedge clk);
        chk("R9", cmi_out, 1'b0, -1);
        chk("R9", bin_out, 1'b0, -1);
        chk("R9", cmi_clk_out, 1'b0, -1);
        chk("R9", bin_clk_out, 1'b0, -1);
        chk("R9", mode_err, 1'b0, -1);
        rst_n = 1'b1; bin_in = bb[0]; cmi_in = sym[0];
        for (int m = 0; m < 2 * nbits; m++) begin
            @(posedge clk);
            @(negedge clk);
            check_edge(lb, lc, pat, m);
            if (m + 1 < 2 * nbits) begin
                bin_in = bb[(m+1)/2];
                cmi_in = sym[m+1];
            end
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 1'b0; bin_in = 1'b0; cmi_in = 1'b0; loop_bin = 1'b0; loop_cmi = 1'b0;
        run(1'b0, 1'b0, 1, 12);   // R1 all zeros
        run(1'b0, 1'b0, 2, 12);   // R1 all ones alternate
        run(1'b0, 1'b0, 0, 40);   // R2 R3 random
        run(1'b1, 1'b0, 0, 40);   // R5 R6 binary loopback
        run(1'b1, 1'b0, 2, 10);   // R5 constant ones
        run(1'b0, 1'b1, 0, 40);   // R7 CMI loopback
        run(1'b0, 1'b1, 2, 10);   // R7 constant ones
        run(1'b1, 1'b1, 0, 10);   // R8 invalid mode
        run(1'b0, 1'b0, 0, 30);   // R9 restart after reset
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule